// File: doc/BRIEF.md
# Triggered Raw Sample Recorder

This block steers a circular store of raw converter samples. It writes every valid sample into a 1024-entry ring for as long as it is recording. When an enabled trigger arrives, it stops writing and can replay a window of the ring toward a serial link. Afterwards it either goes back to recording or holds the ring still so that software can read it out. The RAM and the serializer sit outside the block. The block only produces their write address and enable, their read address and enable, and the send-active indication.

Four trigger sources are accepted, and each has its own enable bit:
- a framework accept;
- a monitoring accept;
- a software accept;
- a self trigger, which the block derives from the sample stream itself.

A framework accept on its own leads back to recording. Any of the other three sources leaves the ring frozen until a resume command arrives. When the ring is disturbed, the block captures the current crossing count and turn count so that software can tell which beam crossing was kept.

Top module: `raw_capture_seq`

## Requirements
- R1: After reset the sequencer is in Recording, the write address is 0 and both latched counters are 0. An accepted trigger seen in Recording moves the sequencer to Suspending on the next clock. Suspending lasts exactly one cycle.
- R2: Trigger enable bits are trg_mask[0] for the framework accept, [1] for monitoring, [2] for software and [3] for self. A flag whose enable bit is 0 has no effect.
- R3: In Recording, every cycle with smp_valid high asserts wr_en at wr_addr, and wr_addr then advances by one modulo 1024. Outside Recording, wr_en stays low and wr_addr holds its value.
- R4: With send_en low, Suspending goes straight to Resuming or Frozen, and rd_en is never asserted.
- R5: A burst whose accepted flags are only the framework accept ends in Resuming. A burst with any accepted monitoring, software or self flag ends in Frozen. Frozen is left only on resume_cmd. Resuming lasts one cycle and is followed by Recording.
- R6: With send_en high, Sending lasts B+1 cycles with rd_en high. rd_addr starts at (last write address + L) mod 1024 and rises by one modulo 1024 each cycle. The last write address is the most recent write, counting a write made in the trigger cycle, and is 1023 before any write has happened.
- R7: While Frozen, accepts of any kind start neither a send nor any state change.
- R8: On the Suspending cycle, last_bx and last_turn capture bx_cnt and turn_cnt. They hold those values until the sequencer re-enters Recording, where they become 0.
- R9: state_oh is one-hot: bit 0 Recording, bit 1 Suspending, bit 2 Sending, bit 3 Resuming, bit 4 Frozen.
- R10: The self flag is raised by a valid sample whose 8 upper bits are strictly greater than self_thr. A sample equal to the threshold does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A raw sample is present this cycle |
| smp_data | input | 10 | Raw sample value |
| trg_fw | input | 1 | Framework accept flag |
| trg_mon | input | 1 | Monitoring accept flag |
| trg_sw | input | 1 | Software accept flag |
| trg_mask | input | 4 | Per-source trigger enables |
| self_thr | input | 8 | Self-trigger threshold |
| send_en | input | 1 | Replay the window after a trigger |
| resume_cmd | input | 1 | Leave Frozen |
| lat_ofs | input | 10 | Window start offset L |
| burst_len | input | 10 | Window length B (B+1 reads) |
| bx_cnt | input | 8 | Current crossing count |
| turn_cnt | input | 16 | Current turn count |
| wr_en | output | 1 | Ring write strobe |
| wr_addr | output | 10 | Ring write address |
| rd_en | output | 1 | Send active, ring read strobe |
| rd_addr | output | 10 | Ring read address |
| last_bx | output | 8 | Crossing count latched at the last suspend |
| last_turn | output | 16 | Turn count latched at the last suspend |
| state_oh | output | 5 | One-hot sequencer state |

## Verification
Two functions can collide in a single cycle.

The first collision is a sample write together with the trigger that stops recording. The bench provokes it by firing the self trigger with the very sample that is being written. It then judges that the replay window starts at that sample's own address plus L, and not at the address of the write before it.

The second collision is the ring pointer wrapping while a window is being read. The bench provokes it by pushing more than 1024 samples and choosing an offset that carries the window across address 0. It then checks each read address against the modulo sum.

// File: rtl/rcap_pkg.sv
package rcap_pkg;
   typedef enum logic [2:0] {
      ST_REC   = 3'd0,
      ST_SUSP  = 3'd1,
      ST_SEND  = 3'd2,
      ST_RESUM = 3'd3,
      ST_FRZ   = 3'd4
   } rcap_state_e;

   localparam int TRG_N    = 4;
   localparam int TRG_FW   = 0;
   localparam int TRG_MON  = 1;
   localparam int TRG_SW   = 2;
   localparam int TRG_SELF = 3;

   localparam int OH_REC   = 0;
   localparam int OH_SUSP  = 1;
   localparam int OH_SEND  = 2;
   localparam int OH_RESUM = 3;
   localparam int OH_FRZ   = 4;
   localparam int OH_N     = 5;
endpackage

// File: rtl/rcap_trig.sv
module rcap_trig
   import rcap_pkg::*;
#(
   parameter int SMP_W = 10,
   parameter int THR_W = 8
) (
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   input  logic [THR_W-1:0] self_thr,
   input  logic             trg_fw,
   input  logic             trg_mon,
   input  logic             trg_sw,
   input  logic [TRG_N-1:0] trg_mask,
   output logic [TRG_N-1:0] trg_eff
);
   localparam int TOP_LSB = SMP_W - THR_W;

   generate
      if (THR_W > SMP_W) begin : g_bad_thr
         $error("rcap_trig: threshold wider than sample");
      end
   endgenerate

   logic [TRG_N-1:0] raw;
   logic             self_hit;

   // R10: strict compare on the upper sample bits
   assign self_hit = smp_valid && (smp_data[SMP_W-1:TOP_LSB] > self_thr);

   always_comb begin
      raw           = '0;
      raw[TRG_FW]   = trg_fw;
      raw[TRG_MON]  = trg_mon;
      raw[TRG_SW]   = trg_sw;
      raw[TRG_SELF] = self_hit;
   end

   for (genvar g = 0; g < TRG_N; g++) begin : g_mask
      assign trg_eff[g] = raw[g] & trg_mask[g];   // R2
   end
endmodule

// File: rtl/rcap_addr.sv
module rcap_addr #(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rec,
   input  logic              smp_valid,
   input  logic              arm,
   input  logic              send,
   input  logic [ADDR_W-1:0] lat_ofs,
   input  logic [ADDR_W-1:0] burst_len,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              send_last
);
   generate
      if (ADDR_W < 2) begin : g_bad_aw
         $error("rcap_addr: ring too small");
      end
   endgenerate

   logic [ADDR_W-1:0] wptr, lw_q, lw_now, base_q, cnt_q;

   assign wr_en     = rec && smp_valid;
   assign wr_addr   = wptr;
   assign lw_now    = wr_en ? wptr : lw_q;
   assign rd_en     = send;
   assign rd_addr   = base_q + cnt_q;
   assign send_last = send && (cnt_q == burst_len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr   <= '0;
         lw_q   <= '1;
         base_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (wr_en) begin
            wptr <= wptr + 1'b1;
            lw_q <= wptr;
         end
         if (arm) begin
            base_q <= lw_now + lat_ofs;
            cnt_q  <= '0;
         end else if (send) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> wr_addr == $past(wr_addr) + 1'b1);                     // R3
   AST_WPTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rec |=> $stable(wr_addr));                                      // R3
   AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !send_last |=> rd_en && rd_addr == $past(rd_addr) + 1'b1); // R6
endmodule

// File: rtl/rcap_fsm.sv
module rcap_fsm
   import rcap_pkg::*;
#(
   parameter int BX_W   = 8,
   parameter int TURN_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TRG_N-1:0]  trg_eff,
   input  logic              send_en,
   input  logic              resume_cmd,
   input  logic              send_last,
   input  logic [BX_W-1:0]   bx_cnt,
   input  logic [TURN_W-1:0] turn_cnt,
   output logic              rec,
   output logic              arm,
   output logic              send,
   output logic [BX_W-1:0]   last_bx,
   output logic [TURN_W-1:0] last_turn,
   output logic [OH_N-1:0]   state_oh
);
   rcap_state_e st_q, st_d;
   logic        frz_q;
   logic        frz_now;

   assign rec     = (st_q == ST_REC);
   assign send    = (st_q == ST_SEND);
   assign arm     = rec && (|trg_eff);
   assign frz_now = |trg_eff[TRG_SELF:TRG_MON];

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_REC:   if (arm) st_d = ST_SUSP;
         ST_SUSP:  st_d = send_en ? ST_SEND : (frz_q ? ST_FRZ : ST_RESUM);
         ST_SEND:  if (send_last) st_d = frz_q ? ST_FRZ : ST_RESUM;
         ST_RESUM: st_d = ST_REC;
         ST_FRZ:   if (resume_cmd) st_d = ST_RESUM;
         default:  st_d = ST_REC;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_REC;
         frz_q     <= 1'b0;
         last_bx   <= '0;
         last_turn <= '0;
      end else begin
         st_q <= st_d;
         if (arm) frz_q <= frz_now;
         if (st_q == ST_SUSP) begin
            last_bx   <= bx_cnt;
            last_turn <= turn_cnt;
         end else if (st_q == ST_RESUM) begin
            last_bx   <= '0;
            last_turn <= '0;
         end
      end
   end

   always_comb begin
      state_oh           = '0;
      state_oh[OH_REC]   = (st_q == ST_REC);
      state_oh[OH_SUSP]  = (st_q == ST_SUSP);
      state_oh[OH_SEND]  = (st_q == ST_SEND);
      state_oh[OH_RESUM] = (st_q == ST_RESUM);
      state_oh[OH_FRZ]   = (st_q == ST_FRZ);
   end

   AST_SUSP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_SUSP |=> st_q != ST_SUSP);                            // R1
   AST_SKIP_SEND: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_SUSP && !send_en |=> st_q != ST_SEND);                // R4
   AST_FRZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_FRZ && !resume_cmd |=> st_q == ST_FRZ);               // R7
   AST_FRZ_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_FRZ && resume_cmd |=> st_q == ST_RESUM);              // R5
   AST_LATCH_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == ST_RESUM |=> last_bx == '0 && last_turn == '0);          // R8
endmodule

// File: rtl/raw_capture_seq.sv
module raw_capture_seq
   import rcap_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int SMP_W  = 10,
   parameter int THR_W  = 8,
   parameter int BX_W   = 8,
   parameter int TURN_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [SMP_W-1:0]  smp_data,
   input  logic              trg_fw,
   input  logic              trg_mon,
   input  logic              trg_sw,
   input  logic [3:0]        trg_mask,
   input  logic [THR_W-1:0]  self_thr,
   input  logic              send_en,
   input  logic              resume_cmd,
   input  logic [ADDR_W-1:0] lat_ofs,
   input  logic [ADDR_W-1:0] burst_len,
   input  logic [BX_W-1:0]   bx_cnt,
   input  logic [TURN_W-1:0] turn_cnt,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic              rd_en,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [BX_W-1:0]   last_bx,
   output logic [TURN_W-1:0] last_turn,
   output logic [4:0]        state_oh
);
   logic [TRG_N-1:0] trg_eff;
   logic             rec, arm, send, send_last;

   rcap_trig #(.SMP_W(SMP_W), .THR_W(THR_W)) i_trig (
      .smp_valid(smp_valid), .smp_data(smp_data), .self_thr(self_thr),
      .trg_fw(trg_fw), .trg_mon(trg_mon), .trg_sw(trg_sw),
      .trg_mask(trg_mask), .trg_eff(trg_eff)
   );

   rcap_fsm #(.BX_W(BX_W), .TURN_W(TURN_W)) i_fsm (
      .clk(clk), .rst_n(rst_n), .trg_eff(trg_eff), .send_en(send_en),
      .resume_cmd(resume_cmd), .send_last(send_last), .bx_cnt(bx_cnt),
      .turn_cnt(turn_cnt), .rec(rec), .arm(arm), .send(send),
      .last_bx(last_bx), .last_turn(last_turn), .state_oh(state_oh)
   );

   rcap_addr #(.ADDR_W(ADDR_W)) i_addr (
      .clk(clk), .rst_n(rst_n), .rec(rec), .smp_valid(smp_valid),
      .arm(arm), .send(send), .lat_ofs(lat_ofs), .burst_len(burst_len),
      .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en), .rd_addr(rd_addr),
      .send_last(send_last)
   );

   AST_STATE_OH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(state_oh));                                              // R9
   AST_FRZ_NO_RD: assert property (@(posedge clk) disable iff (!rst_n)
      state_oh[OH_FRZ] |-> !rd_en && !wr_en);                          // R7
endmodule

// File: tb/test_raw_capture_seq.sv
module test_raw_capture_seq;
   localparam int DEPTH = 1024;
   localparam logic [4:0] S_REC = 5'b00001, S_SUSP = 5'b00010,
      S_SEND = 5'b00100, S_RESUM = 5'b01000, S_FRZ = 5'b10000;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, smp_valid, trg_fw, trg_mon, trg_sw, send_en, resume_cmd;
   logic [9:0] smp_data, lat_ofs, burst_len;
   logic [3:0] trg_mask;
   logic [7:0] self_thr, bx_cnt;
   logic [15:0] turn_cnt;
   logic wr_en, rd_en;
   logic [9:0] wr_addr, rd_addr;
   logic [7:0] last_bx;
   logic [15:0] last_turn;
   logic [4:0] state_oh;

   raw_capture_seq i_raw_capture_seq (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
      .trg_fw(trg_fw), .trg_mon(trg_mon), .trg_sw(trg_sw), .trg_mask(trg_mask),
      .self_thr(self_thr), .send_en(send_en), .resume_cmd(resume_cmd),
      .lat_ofs(lat_ofs), .burst_len(burst_len), .bx_cnt(bx_cnt),
      .turn_cnt(turn_cnt), .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en),
      .rd_addr(rd_addr), .last_bx(last_bx), .last_turn(last_turn),
      .state_oh(state_oh)
   );

   int n_chk = 0, n_bad = 0, bw = 0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic idle_inputs();
      smp_valid = 0; trg_fw = 0; trg_mon = 0; trg_sw = 0; resume_cmd = 0;
      smp_data = 10'h100;
   endtask

   task automatic write_n(input int n);
      for (int i = 0; i < n; i++) begin
         smp_valid = 1; smp_data = 10'h100;
         chk("R3 wr_en", 32'(wr_en), 1);
         chk("R3 wr_addr", 32'(wr_addr), 32'(bw % DEPTH));
         step();
         bw++;
      end
      smp_valid = 0;
      chk("R3 wr_addr after", 32'(wr_addr), 32'(bw % DEPTH));
   endtask

   task automatic fire(input logic [3:0] fl, input logic [3:0] msk, input bit snd,
                       input int L, input int B, input logic [7:0] xb, input logic [15:0] xt);
      logic [3:0] eff;
      int last, start, hold;
      bit frz;
      eff = fl & msk;
      frz = |eff[3:1];
      trg_mask = msk; send_en = snd; lat_ofs = 10'(L); burst_len = 10'(B);
      trg_fw = fl[0]; trg_mon = fl[1]; trg_sw = fl[2];
      smp_valid = fl[3]; smp_data = fl[3] ? 10'h3FF : 10'h100;
      bx_cnt = 8'hEE; turn_cnt = 16'hEEEE;
      last = fl[3] ? (bw % DEPTH) : ((bw + DEPTH - 1) % DEPTH);
      start = (last + L) % DEPTH;
      step();
      if (fl[3]) bw++;
      if (eff == 4'b0) begin
         chk("R2 masked flags ignored", 32'(state_oh), 32'(S_REC));
         idle_inputs();
         return;
      end
      chk("R1 suspending", 32'(state_oh), 32'(S_SUSP));
      hold = bw % DEPTH;
      // keep stimulus live while not recording: nothing may be written or retriggered
      smp_valid = 1; smp_data = 10'h3FF; trg_fw = 1;
      bx_cnt = xb; turn_cnt = xt;
      chk("R3 no write in suspend", 32'(wr_en), 0);
      step();
      chk("R8 latched bx", 32'(last_bx), 32'(xb));
      chk("R8 latched turn", 32'(last_turn), 32'(xt));
      bx_cnt = 8'h11; turn_cnt = 16'h2222;
      if (snd) begin
         for (int i = 0; i <= B; i++) begin
            chk("R6 sending state", 32'(state_oh), 32'(S_SEND));
            chk("R6 rd_en", 32'(rd_en), 1);
            chk("R6 rd_addr", 32'(rd_addr), 32'((start + i) % DEPTH));
            chk("R3 wr_addr held", 32'(wr_addr), 32'(hold));
            step();
         end
      end else begin
         chk("R4 no read when disabled", 32'(rd_en), 0);
      end
      if (frz) begin
         chk("R5 frozen after freezing trigger", 32'(state_oh), 32'(S_FRZ));
         for (int i = 0; i < 3; i++) begin
            step();
            chk("R7 frozen ignores accepts", 32'(state_oh), 32'(S_FRZ));
            chk("R7 no read while frozen", 32'(rd_en), 0);
         end
         chk("R8 latch held while frozen", 32'(last_bx), 32'(xb));
         resume_cmd = 1;
         step();
         resume_cmd = 0;
      end
      chk("R5 resuming", 32'(state_oh), 32'(S_RESUM));
      chk("R8 latch held in resuming", 32'(last_turn), 32'(xt));
      step();
      chk("R5 back to recording", 32'(state_oh), 32'(S_REC));
      chk("R8 latch cleared bx", 32'(last_bx), 0);
      chk("R8 latch cleared turn", 32'(last_turn), 0);
      chk("R3 wr_addr unchanged", 32'(wr_addr), 32'(hold));
      idle_inputs();
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      idle_inputs();
      rst_n = 0; trg_mask = 4'hF; self_thr = 8'h80; send_en = 1;
      lat_ofs = 0; burst_len = 0; bx_cnt = 0; turn_cnt = 0;
      repeat (3) step();
      rst_n = 1;
      chk("R1 reset state", 32'(state_oh), 32'(S_REC));
      chk("R1 reset wr_addr", 32'(wr_addr), 0);
      chk("R1 reset last_bx", 32'(last_bx), 0);
      chk("R1 reset last_turn", 32'(last_turn), 0);
      chk("R9 reset rd_en", 32'(rd_en), 0);

      // window before any write: last address is 1023
      fire(4'b0001, 4'hF, 1'b1, 3, 2, 8'h5A, 16'hA5A5);
      write_n(20);

      // R10 boundary: upper bits equal to threshold does not trigger
      smp_valid = 1; smp_data = {8'h80, 2'b11};
      step(); bw++;
      chk("R10 equal threshold ignored", 32'(state_oh), 32'(S_REC));
      smp_data = {8'h7F, 2'b11};
      step(); bw++;
      chk("R10 below threshold ignored", 32'(state_oh), 32'(S_REC));
      idle_inputs();

      // R2 each flag masked off alone
      for (int f = 0; f < 4; f++) begin
         fire(4'(1 << f), ~4'(1 << f), 1'b1, 5, 3, 8'h01, 16'h0001);
      end

      // sweep every flag combination, both send modes
      for (int c = 1; c < 16; c++) begin
         write_n(c + 2);
         fire(4'(c), 4'hF, 1'(c % 2), (c * 37) % DEPTH, c % 7,
              8'(8'h30 + c), 16'(16'h1200 + c));
         fire(4'(c), 4'hF, 1'(1 - (c % 2)), (c * 91) % DEPTH, (c * 3) % 5,
              8'(8'h60 + c), 16'(16'h3400 + c));
      end

      // ring wrap on write pointer and on read window
      write_n(1030);
      fire(4'b0001, 4'hF, 1'b1, 1020, 9, 8'hC3, 16'hBEEF);
      fire(4'b1000, 4'hF, 1'b1, 1023, 4, 8'h3C, 16'hF00D);

      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule